// File: doc/BRIEF.md
# Dual-Output Gate Pulse Steering with Leading-Edge Blanking

This block turns an oscillator's dead-time strobe and a set of synchronous comparator results into gate-drive pulses for two outputs. A pulse opens when the strobe falls and closes on the first of three causes: a PWM comparator trip, a current-limit trip, or an overcurrent fault. While the strobe is high, which is the oscillator's discharge interval, both outputs are held low. This caps the maximum duty cycle.

For a programmable number of system clocks after each pulse opens, a blanking window masks the PWM and current-limit inputs. This lets switching noise at turn-on pass without ending the pulse. The overcurrent input and the global enable input are never masked and take effect in the same cycle. In in-phase mode both outputs carry every pulse. In alternating mode a toggle flop, which advances on every strobe fall, sends each pulse to one output only, so each output runs at half the oscillator rate.

Top module: `pwm_pulse_steer`

## Requirements
- R1: While reset is asserted, and after it is released, both drive outputs and the blanking flag are low. In alternating mode, the first pulse after reset goes to drive A.
- R2: Whenever the strobe input is high, both drive outputs are low in that same cycle.
- R3: When the strobe is sampled low at a clock edge after being sampled high at the edge before, a pulse starts. The enabled outputs are high from the next cycle, as long as no terminating condition is present.
- R4: Outside the blanking window, a PWM trip drives the outputs low in the same cycle. They stay low until the next pulse start, even after the trip input returns low.
- R5: The blanking window covers the first L cycles of each pulse, where L is the value on blank_len_i when the pulse starts. During the window, PWM and current-limit trips have no effect and the blanking flag is high. The flag is low at all other times. L = 0 disables blanking.
- R6: Outside the blanking window, a current-limit trip ends the pulse in the same cycle. The pulse stays ended until the next pulse start.
- R7: The overcurrent input is never blanked. While it is high both outputs are low in that cycle, and the pulse does not resume when the input drops. If the input is high on the start cycle, no pulse opens in that oscillator cycle.
- R8: In alternating mode (alt_mode_i = 1), pulses go to A and B in turn, one output per oscillator cycle. The output that is not selected stays low, and the two are never high together.
- R9: In in-phase mode (alt_mode_i = 0), both outputs are equal in every cycle.
- R10: While en_i is low, both outputs are low in that cycle, and the pulse does not resume when en_i returns high. If en_i is low on the start cycle, no pulse opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low forces both outputs low |
| osc_strobe_i | input | 1 | Oscillator dead-time strobe, high during discharge |
| pwm_trip_i | input | 1 | Synchronous PWM comparator result |
| ilim_trip_i | input | 1 | Synchronous current-limit comparator result |
| ocp_fault_i | input | 1 | Synchronous overcurrent fault, never blanked |
| alt_mode_i | input | 1 | 1 = alternating outputs, 0 = in-phase |
| blank_len_i | input | BLANK_W | Blanking length in clock cycles |
| drv_a_o | output | 1 | Gate drive A |
| drv_b_o | output | 1 | Gate drive B |
| blank_act_o | output | 1 | High while the blanking window is open |

## Verification
The registered edge detector places the pulse start one cycle after the first low strobe sample. From that cycle, the blanking flag is high for exactly L cycles. Every terminating cause (strobe, overcurrent, enable, or an unblanked trip) acts on the outputs in the cycle it is presented, with no added register. The bench drives inputs on the falling clock edge and samples 1 ns later. It therefore compares each cycle's outputs against an expectation computed from the cycle's index inside the oscillator period, the trip position and L. A single-cycle trip pulse, swept across every position of the low phase, also shows that an ended pulse stays low after the trip input clears.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned NUM_DRV = 2;
  typedef logic [NUM_DRV-1:0] drv_vec_t;
  typedef enum logic {
    MODE_INPHASE = 1'b0,
    MODE_ALT     = 1'b1
  } steer_mode_e;
endpackage

// File: rtl/pps_edge.sv
module pps_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic start
);
  logic strobe_q;
  logic strobe_d;

  always_comb begin
    strobe_d = strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  // Falling strobe seen at this edge opens a new oscillator cycle
  assign start = strobe_q & ~strobe;
endmodule

// File: rtl/pps_blank.sv
module pps_blank #(
  parameter int unsigned BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLANK_W-1:0] len,
  output logic               active
);
  localparam logic [BLANK_W-1:0] ONE  = BLANK_W'(1);
  localparam logic [BLANK_W-1:0] ZERO = '0;

  logic [BLANK_W-1:0] cnt_q;
  logic [BLANK_W-1:0] cnt_d;
  logic               cnt_en;

  assign active = (cnt_q != ZERO);
  assign cnt_en = start | active;

  always_comb begin
    if (start) cnt_d = len;
    else       cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: a zero length leaves the window closed
  p_zero_len_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len == ZERO) |=> !active);

  // R5: a nonzero length opens the window on the next cycle
  p_window_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != ZERO) |=> active);
endmodule

// File: rtl/pps_pulse.sv
module pps_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic en,
  input  logic ocp,
  input  logic strobe,
  input  logic pwm_trip,
  input  logic ilim_trip,
  input  logic blank_act,
  output logic live
);
  logic pulse_q;
  logic pulse_d;
  logic pulse_en;
  logic hard_stop;
  logic soft_stop;
  logic term;
  logic set;

  assign hard_stop = ocp | ~en | strobe;
  assign soft_stop = ~blank_act & (pwm_trip | ilim_trip);
  assign term      = hard_stop | soft_stop;
  assign set       = start & en & ~ocp;
  assign pulse_en  = set | (pulse_q & term);

  always_comb begin
    if (set) pulse_d = 1'b1;
    else     pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_q <= 1'b0;
    else if (pulse_en) pulse_q <= pulse_d;
  end

  assign live = pulse_q & ~term;

  // R5: comparator trips inside the window never end the pulse
  p_blank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && blank_act && !hard_stop) |=> pulse_q);

  // R4: an ended pulse stays ended until the next start
  p_latched_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_q && !start) |=> !pulse_q);

  // R7: overcurrent kills the pulse within the cycle
  p_ocp_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ocp |-> !live);
endmodule

// File: rtl/pps_steer.sv
module pps_steer
  import pps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  steer_mode_e mode,
  input  logic        live,
  output drv_vec_t    drv
);
  logic     tgl_q;
  logic     tgl_d;
  drv_vec_t sel;

  always_comb begin
    tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tgl_q <= 1'b0;
    else if (start) tgl_q <= tgl_d;
  end

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
    if (i == 0) begin : g_even
      assign sel[i] = (mode == MODE_INPHASE) | tgl_q;
    end else begin : g_odd
      assign sel[i] = (mode == MODE_INPHASE) | ~tgl_q;
    end
    assign drv[i] = live & sel[i];
  end

  // R8: alternating mode never drives both outputs together
  p_alt_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ALT) |-> $onehot0(drv));

  // R9: in-phase mode keeps the outputs identical
  p_inphase_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INPHASE) |-> ((&drv) || !(|drv)));
endmodule

// File: rtl/pwm_pulse_steer.sv
module pwm_pulse_steer
  import pps_pkg::*;
#(
  parameter int unsigned BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               osc_strobe_i,
  input  logic               pwm_trip_i,
  input  logic               ilim_trip_i,
  input  logic               ocp_fault_i,
  input  logic               alt_mode_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  output logic               drv_a_o,
  output logic               drv_b_o,
  output logic               blank_act_o
);
  localparam int unsigned SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic                  rst_int_n;
  logic                  start;
  logic                  blank_act;
  logic                  live;
  steer_mode_e           mode;
  drv_vec_t              drv;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_DEPTH-1];

  assign mode = steer_mode_e'(alt_mode_i);

  pps_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .strobe (osc_strobe_i),
    .start  (start)
  );

  pps_blank #(.BLANK_W(BLANK_W)) u_blank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .len    (blank_len_i),
    .active (blank_act)
  );

  pps_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .en        (en_i),
    .ocp       (ocp_fault_i),
    .strobe    (osc_strobe_i),
    .pwm_trip  (pwm_trip_i),
    .ilim_trip (ilim_trip_i),
    .blank_act (blank_act),
    .live      (live)
  );

  pps_steer u_steer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .mode  (mode),
    .live  (live),
    .drv   (drv)
  );

  assign drv_a_o     = drv[0];
  assign drv_b_o     = drv[1];
  assign blank_act_o = blank_act;

  // R2: dead-time strobe blanks both outputs
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    osc_strobe_i |-> (!drv_a_o && !drv_b_o));

  // R10: disable forces both outputs low
  p_disable_low_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_i |-> (!drv_a_o && !drv_b_o));

  // R7: overcurrent forces both outputs low at the ports
  p_ocp_low_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ocp_fault_i |-> (!drv_a_o && !drv_b_o));
endmodule

// File: tb/tb_pwm_pulse_steer.sv
`timescale 1ns/1ps
module tb_pwm_pulse_steer;
  localparam int BW = 8;
  localparam int D  = 3;   // strobe-high cycles per period
  localparam int L  = 8;   // strobe-low cycles per period
  localparam int NMAX = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic en_i, osc_strobe_i, pwm_trip_i, ilim_trip_i, ocp_fault_i, alt_mode_i;
  logic [BW-1:0] blank_len_i;
  logic drv_a_o, drv_b_o, blank_act_o;

  int checks = 0;
  int fails  = 0;
  int p      = 0;

  always #10 clk = ~clk;

  pwm_pulse_steer #(.BLANK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .osc_strobe_i(osc_strobe_i),
    .pwm_trip_i(pwm_trip_i), .ilim_trip_i(ilim_trip_i), .ocp_fault_i(ocp_fault_i),
    .alt_mode_i(alt_mode_i), .blank_len_i(blank_len_i),
    .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .blank_act_o(blank_act_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (period %0d)", tag, what, act, exp, p);
    end
  endtask

  task automatic drive(input logic s, input logic pw, input logic il, input logic oc, input logic en);
    @(negedge clk);
    osc_strobe_i = s; pwm_trip_i = pw; ilim_trip_i = il; ocp_fault_i = oc; en_i = en;
    #1;
  endtask

  function automatic string tag_for(input int src, input int t, input int n, input int j,
                                    input bit mode, input bit sel, input bit is_b);
    if (j == 0)                     return "R3";
    if (p == 0)                     return "R1";
    if (mode && !sel)               return "R8";
    if (!mode && is_b)              return "R9";
    if (j >= t && src < 2 && t <= n) return "R5";
    if (j >= t && src == 0)         return "R4";
    if (j >= t && src == 1)         return "R6";
    if (j >= t && src == 2)         return "R7";
    if (j >= t && src == 3)         return "R10";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en_i = 1'b1; osc_strobe_i = 1'b1; pwm_trip_i = 1'b0; ilim_trip_i = 1'b0;
    ocp_fault_i = 1'b0; alt_mode_i = 1'b1; blank_len_i = '0;
    repeat (3) begin
      @(negedge clk); #1;
      check("R1", "drv_a in reset", drv_a_o, 1'b0);
      check("R1", "drv_b in reset", drv_b_o, 1'b0);
      check("R1", "blank in reset", blank_act_o, 1'b0);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R1", "drv_a after reset", drv_a_o, 1'b0);
      check("R1", "blank after reset", blank_act_o, 1'b0);
    end

    for (int m = 1; m >= 0; m--) begin
      for (int n = 0; n <= NMAX; n++) begin
        for (int src = 0; src < 4; src++) begin
          for (int t = 0; t <= L; t++) begin
            bit sel_a, sel_b, base;
            @(negedge clk);
            alt_mode_i  = m[0];
            blank_len_i = BW'(n);
            for (int d = 0; d < D; d++) begin
              drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
              check("R2", "drv_a strobe", drv_a_o, 1'b0);
              check("R2", "drv_b strobe", drv_b_o, 1'b0);
              check("R5", "blank strobe", blank_act_o, 1'b0);
            end
            sel_a = (m == 0) || (p % 2 == 0);
            sel_b = (m == 0) || (p % 2 == 1);
            for (int j = 0; j < L; j++) begin
              bit trip;
              bit killed;
              trip = (j == t);
              drive(1'b0, trip && src == 0, trip && src == 1, trip && src == 2,
                    !(trip && src == 3));
              killed = ((src < 2) ? (t > n) : 1'b1) && (j >= t);
              base   = (j >= 1) && !killed;
              check(tag_for(src, t, n, j, m[0], sel_a, 1'b0), "drv_a", drv_a_o, base && sel_a);
              check(tag_for(src, t, n, j, m[0], sel_b, 1'b1), "drv_b", drv_b_o, base && sel_b);
              check("R5", "blank flag", blank_act_o, (j >= 1) && (j <= n));
            end
            p++;
          end
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule